// File: doc/BRIEF.md
# Oversampling serial receiver with bus-break detection

This block turns a single asynchronous serial input into parallel characters. A programmable divider produces an oversampling tick, sixteen ticks make one bit time, and each bit is decided by a vote of three samples taken around the middle of the bit. A frame is a low start bit, seven or eight data bits sent least-significant bit first, an optional parity bit and one or two high stop bits. Each character is presented on `rx_data` together with a single-cycle `rx_valid`. Four sticky flags report a low stop bit, a parity mismatch, an unread character that was overwritten, and a line that stayed low for eleven bit times (the break field of a LIN bus).

After a framing error the receiver does not wait for an edge. If the line is still low when the next frame would begin, that low level counts as a start bit. This lets a continuously low line be tracked frame by frame. Dropping `rx_en` and raising it again cancels this and sends the receiver back to idle, where only a real falling edge can start a frame. The frame format and the baud divider are copied from the configuration inputs only at reset and on a `soft_rst` strobe. Software changes them while reception is disabled and then issues a soft reset.

Top module: `lin_serial_rx`

## Requirements
- R1: The oversampling tick occurs once every `cfg_div`+1 clocks, and one bit lasts 16 ticks. Data bits are assembled least-significant bit first, each decided by a majority of the samples at ticks 7, 8 and 9 of the bit. The character appears on `rx_data` with a one-cycle `rx_valid` at the first stop-bit sample.
- R2: With parity enabled, the parity bit follows the data bits. `cfg_par_odd`=0 expects an even count of ones over the data and parity bits, and 1 expects an odd count. A mismatch sets `parity_err`.
- R3: With `cfg_len_full`=1 a frame carries 8 data bits. With 0 it carries 7 data bits and `rx_data[7]` reads 0. With `cfg_two_stop`=1 two stop bits are expected, and a low sample in either one sets `frame_err`.
- R4: A stop-bit sample that reads low sets `frame_err`, and the character is still delivered.
- R5: After a framing error with `rx_en` held high, a line still low at the end of the stop bit starts a new frame without any falling edge. On a held-low line every further frame is delivered as data 0x00 with `frame_err` set.
- R6: While `rx_en` is low the receiver idles and the break counter is cleared. After `rx_en` goes 1→0→1, a held-low line starts no frame until the line has gone high and fallen again.
- R7: A falling edge starts a frame only if the start bit votes low at its middle. A low pulse shorter than half a bit produces no character and no flag.
- R8: `break_det` sets once the line has been low for 11 bit times while receiving is enabled. A low period of 10 bit times does not set it. It stays set until cleared.
- R9: If a character is delivered while the previous one has not been acknowledged with `rd_ack`, `overrun_err` sets and `rx_data` takes the new character.
- R10: `err_clr` clears all four flags and does not disturb a frame in progress. If a flag is set in the same cycle as `err_clr`, the flag ends up set.
- R11: Format and divider changes take effect only at reset or `soft_rst`. `soft_rst` also returns the receiver to idle and clears the flags, `rx_data` and the pending-character state.
- R12: After reset, `rx_data` is 0 and `rx_valid`, `frame_err`, `parity_err`, `overrun_err` and `break_det` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receive enable |
| err_clr | input | 1 | Strobe that clears all error and break flags |
| soft_rst | input | 1 | Strobe that resets the receiver and loads the configuration |
| rd_ack | input | 1 | Strobe that marks the current character as read |
| cfg_div | input | 12 | Baud divider: one tick every cfg_div+1 clocks |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_len_full | input | 1 | 8 data bits when 1, 7 when 0 |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| frame_err | output | 1 | Sticky low-stop-bit flag |
| parity_err | output | 1 | Sticky parity mismatch flag |
| overrun_err | output | 1 | Sticky unread-character-overwritten flag |
| break_det | output | 1 | Sticky 11-bit-low break flag |

## Verification
The error-clear strobe and the setting of the framing flag can fall in the same clock, and the design defines that the set wins. The bench provokes this by first calibrating. It issues a soft reset, which restarts the baud divider, sends a frame with a low stop bit and counts the clocks until `rx_valid` appears. It then repeats the same soft reset and frame and raises `err_clr` for exactly that clock. The check passes if `frame_err` reads set after that clock.

// File: rtl/lin_rx_pkg.sv
// Shared types for the serial receiver: receiver states, the latched
// frame format and the three-sample vote used for every bit decision.
package lin_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_GAP
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic len_full;
    } rx_fmt_t;

    // Majority of three samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lin_rx_baud.sv
// Oversampling tick generator. Emits a one-clock tick every div+1 clocks.
// Assumes div only changes in the same cycle as a soft reset, which
// restarts the count so the tick phase is known afterwards.
module lin_rx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count up to div, then wrap and emit a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R1: the divider count never passes the programmed limit
    p_div_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div);

    // R1: with a divider above zero, ticks are never back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && !soft_rst) |=> !tick);

endmodule

// File: rtl/lin_rx_line.sv
// Input conditioning. Brings the asynchronous line into the clock domain
// through two flops and flags a high-to-low transition. Reset to the idle
// (high) level so that reset itself never looks like an edge.
module lin_rx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic line,
    output logic fall
);

    logic meta_q, sync_q, prev_q;

    // Two-stage synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line = sync_q;
    assign fall = prev_q & ~sync_q;

endmodule

// File: rtl/lin_rx_break.sv
// Break detector. Counts oversampling ticks while the synchronized line
// is low and receiving is enabled. Reaching BREAK_BITS bit times sets a
// sticky flag. The count restarts whenever the line is high or receiving
// is disabled. The flag is cleared by the error-clear strobe, and a set
// in the same cycle wins over the clear.
module lin_rx_break #(
    parameter int OS         = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic rx_en,
    input  logic err_clr,
    input  logic tick,
    input  logic line,
    output logic break_det
);

    localparam int BRK_TICKS = OS * BREAK_BITS;
    localparam int BCNT_W    = $clog2(BRK_TICKS + 1);

    logic [BCNT_W-1:0] low_cnt_q;

    // Measure the low time in ticks and raise the flag at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            low_cnt_q <= '0;
            break_det <= 1'b0;
        end else begin
            if (err_clr) begin
                break_det <= 1'b0;
            end
            if (!rx_en || line) begin
                low_cnt_q <= '0;
            end else if (tick && low_cnt_q != BCNT_W'(BRK_TICKS)) begin
                low_cnt_q <= low_cnt_q + 1'b1;
                if (low_cnt_q == BCNT_W'(BRK_TICKS - 1)) begin
                    break_det <= 1'b1;
                end
            end
        end
    end

    // R8: the break flag only rises after a cycle with the line low
    p_brk_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_det) |-> ($past(line) == 1'b0));

    // R8: the low-time counter saturates at the threshold
    p_brk_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= BCNT_W'(BRK_TICKS));

endmodule

// File: rtl/lin_rx_frame.sv
// Frame sequencer. Waits for a falling edge, confirms the start bit at its
// middle, shifts in data least-significant bit first, checks parity and
// stop bits, and delivers the character at the first stop sample. After a
// low stop bit it waits out the bit and re-enters the start state with no
// edge, so a held-low line is taken as a new frame. Assumes tick comes
// from the divider and line/fall from the synchronizer.
module lin_rx_frame
    import lin_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_en,
    input  logic              err_clr,
    input  logic              rd_ack,
    input  logic              tick,
    input  logic              line,
    input  logic              fall,
    input  rx_fmt_t           fmt,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun_err
);

    localparam int CNT_W = $clog2(OS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MID   = OS / 2;

    rx_state_e         state;
    logic [CNT_W-1:0]  os_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              samp_a, samp_b;
    logic              par_acc;
    logic              data_full;

    logic              mid_pt, bit_end, vote;
    logic [IDX_W-1:0]  last_idx;

    // Decision points within a bit and the value voted for it.
    always_comb begin
        mid_pt   = tick && (os_cnt == CNT_W'(MID + 1));
        bit_end  = tick && (os_cnt == CNT_W'(OS - 1));
        vote     = vote3(samp_a, samp_b, line);
        last_idx = fmt.len_full ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    end

    // Receiver state, bit assembly, delivery and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state       <= ST_IDLE;
            os_cnt      <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            samp_a      <= 1'b1;
            samp_b      <= 1'b1;
            par_acc     <= 1'b0;
            data_full   <= 1'b0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            frame_err   <= 1'b0;
            parity_err  <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (err_clr) begin
                frame_err   <= 1'b0;
                parity_err  <= 1'b0;
                overrun_err <= 1'b0;
            end
            if (rd_ack) begin
                data_full <= 1'b0;
            end
            if (!rx_en) begin
                state <= ST_IDLE;
            end else begin
                if (tick) begin
                    os_cnt <= (os_cnt == CNT_W'(OS - 1)) ? '0 : os_cnt + 1'b1;
                    if (os_cnt == CNT_W'(MID - 1)) samp_a <= line;
                    if (os_cnt == CNT_W'(MID))     samp_b <= line;
                end
                case (state)
                    ST_IDLE: begin
                        if (fall) begin
                            state  <= ST_START;
                            os_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (mid_pt && vote) begin
                            state <= ST_IDLE;
                        end else if (bit_end) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                            par_acc <= 1'b0;
                            shreg   <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (mid_pt) begin
                            shreg[bit_idx] <= vote;
                            par_acc        <= par_acc ^ vote;
                        end
                        if (bit_end) begin
                            if (bit_idx == last_idx) begin
                                state <= fmt.par_en ? ST_PAR : ST_STOP1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (mid_pt && ((par_acc ^ vote) != fmt.par_odd)) begin
                            parity_err <= 1'b1;
                        end
                        if (bit_end) begin
                            state <= ST_STOP1;
                        end
                    end
                    ST_STOP1: begin
                        if (mid_pt) begin
                            rx_data   <= shreg;
                            rx_valid  <= 1'b1;
                            data_full <= 1'b1;
                            if (data_full && !rd_ack) begin
                                overrun_err <= 1'b1;
                            end
                            if (!vote) begin
                                frame_err <= 1'b1;
                            end
                            if (!fmt.two_stop) begin
                                state <= vote ? ST_IDLE : ST_GAP;
                            end
                        end else if (bit_end) begin
                            state <= ST_STOP2;
                        end
                    end
                    ST_STOP2: begin
                        if (mid_pt) begin
                            if (!vote) begin
                                frame_err <= 1'b1;
                            end
                            state <= vote ? ST_IDLE : ST_GAP;
                        end
                    end
                    ST_GAP: begin
                        if (bit_end) begin
                            state <= ST_START;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a character strobe lasts exactly one cycle
    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: the framing flag holds until a clear or soft reset
    p_ferr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr && !soft_rst) |=> frame_err);

    // R6: disabling reception returns the sequencer to idle
    p_disable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE));

    // R9: an overrun only appears together with a delivered character
    p_ovr_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> rx_valid);

endmodule

// File: rtl/lin_serial_rx.sv
// Top of the serial receiver. Holds the active configuration, which is
// copied from the inputs only at reset and on a soft reset, and connects
// the synchronizer, tick generator, frame sequencer and break detector.
module lin_serial_rx
    import lin_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 12,
    parameter int OS         = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic              err_clr,
    input  logic              soft_rst,
    input  logic              rd_ack,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_len_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun_err,
    output logic              break_det
);

    rx_fmt_t          fmt_q;
    logic [DIV_W-1:0] div_q;
    logic             tick, line, fall;

    // Latch the configuration at reset and at each soft reset only.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            fmt_q.par_en   <= cfg_par_en;
            fmt_q.par_odd  <= cfg_par_odd;
            fmt_q.two_stop <= cfg_two_stop;
            fmt_q.len_full <= cfg_len_full;
            div_q          <= cfg_div;
        end
    end

    lin_rx_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .line  (line),
        .fall  (fall)
    );

    lin_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .div      (div_q),
        .tick     (tick)
    );

    lin_rx_frame #(.DATA_W(DATA_W), .OS(OS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .rx_en       (rx_en),
        .err_clr     (err_clr),
        .rd_ack      (rd_ack),
        .tick        (tick),
        .line        (line),
        .fall        (fall),
        .fmt         (fmt_q),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .frame_err   (frame_err),
        .parity_err  (parity_err),
        .overrun_err (overrun_err)
    );

    lin_rx_break #(.OS(OS), .BREAK_BITS(BREAK_BITS)) u_break (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .rx_en     (rx_en),
        .err_clr   (err_clr),
        .tick      (tick),
        .line      (line),
        .break_det (break_det)
    );

    // R11: the active divider only changes at a reset or soft reset
    p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(div_q));

endmodule

// File: tb/tb_lin_serial_rx.sv
module tb_lin_serial_rx;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 12;
    localparam int DIV    = 3;
    localparam int BIT    = 16 * (DIV + 1);

    logic clk = 1'b0;
    logic rst_n, rx_in, rx_en, err_clr, soft_rst, rd_ack;
    logic [DIV_W-1:0] cfg_div;
    logic cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_len_full;
    logic [DATA_W-1:0] rx_data;
    logic rx_valid, frame_err, parity_err, overrun_err, break_det;

    int n_chk = 0;
    int n_err = 0;
    int vcnt  = 0;
    logic [7:0] last_data = '0;

    always #5 clk = ~clk;

    lin_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_en(rx_en),
        .err_clr(err_clr), .soft_rst(soft_rst), .rd_ack(rd_ack),
        .cfg_div(cfg_div), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_len_full(cfg_len_full),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .parity_err(parity_err), .overrun_err(overrun_err), .break_det(break_det)
    );

    // Record every delivered character.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcnt++;
            last_data = rx_data;
        end
    end

    task automatic checkv(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fmt_mask(input bit full);
        return full ? 8'hFF : 8'h7F;
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input bit full, input bit odd);
        return (^(d & fmt_mask(full))) ^ odd;
    endfunction

    task automatic hold(input logic v, input int nbits);
        rx_in = v;
        repeat (nbits * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit full, input bit pe, input bit po,
                        input bit ts, input bit bad_par, input bit bad_s1,
                        input bit bad_s2, input bit keep_low);
        hold(1'b0, 1);
        for (int i = 0; i < (full ? 8 : 7); i++) hold(d[i], 1);
        if (pe) hold(par_bit(d, full, po) ^ bad_par, 1);
        hold(!bad_s1, 1);
        if (ts) hold(!bad_s2, 1);
        rx_in = keep_low ? 1'b0 : 1'b1;
    endtask

    task automatic send_std(input logic [7:0] d, input bit bad_stop, input bit keep_low);
        send(d, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, bad_stop, 1'b0, keep_low);
    endtask

    task automatic pulse_ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
    endtask

    task automatic set_std();
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0; cfg_len_full = 1'b1;
        pulse_soft();
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int v0, cal;
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; rx_in = 1'b1; rx_en = 1'b1; err_clr = 1'b0;
        soft_rst = 1'b0; rd_ack = 1'b0; cfg_div = DIV_W'(DIV);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0; cfg_len_full = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: reset values
        checkv("R12 rx_data", rx_data, 0);
        checkv("R12 rx_valid", rx_valid, 0);
        checkv("R12 frame_err", frame_err, 0);
        checkv("R12 parity_err", parity_err, 0);
        checkv("R12 overrun_err", overrun_err, 0);
        checkv("R12 break_det", break_det, 0);

        // R1: one directed character, least-significant bit first
        v0 = vcnt;
        send_std(8'hA5, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R1 count", vcnt - v0, 1);
        checkv("R1 data", rx_data, 8'hA5);
        checkv("R1 no frame_err", frame_err, 0);
        pulse_ack();

        // R1 R2 R3: random formats and random characters
        for (int g = 0; g < 4; g++) begin
            cfg_par_en   = 1'($urandom % 2);
            cfg_par_odd  = 1'($urandom % 2);
            cfg_two_stop = 1'($urandom % 2);
            cfg_len_full = 1'($urandom % 2);
            pulse_soft();
            for (int k = 0; k < 6; k++) begin
                d = 8'($urandom);
                v0 = vcnt;
                send(d, cfg_len_full, cfg_par_en, cfg_par_odd, cfg_two_stop,
                     1'b0, 1'b0, 1'b0, 1'b0);
                hold(1'b1, 1);
                checkv("R3 random data", rx_data, d & fmt_mask(cfg_len_full));
                checkv("R1 random count", vcnt - v0, 1);
                checkv("R2 random parity ok", parity_err, 0);
                checkv("R3 random frame ok", frame_err, 0);
                checkv("R9 acked no overrun", overrun_err, 0);
                pulse_ack();
            end
        end

        // R2: wrong odd parity sets the flag, and a clear removes it
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b0; cfg_len_full = 1'b1;
        pulse_soft();
        send(8'h6E, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R2 bad parity flag", parity_err, 1);
        checkv("R2 data kept", rx_data, 8'h6E);
        pulse_clr();
        checkv("R10 parity cleared", parity_err, 0);
        pulse_ack();

        // R3: low second stop bit
        cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        pulse_soft();
        send(8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        hold(1'b1, 1);
        checkv("R3 second stop low", frame_err, 1);
        checkv("R3 data delivered", rx_data, 8'h81);
        pulse_ack();
        set_std();

        // R7: short low glitch is rejected
        v0 = vcnt;
        rx_in = 1'b0;
        repeat (3 * (DIV + 1)) @(negedge clk);
        hold(1'b1, 20);
        checkv("R7 no character", vcnt - v0, 0);
        checkv("R7 no flag", frame_err, 0);

        // R4: low stop bit
        send_std(8'h3C, 1'b1, 1'b0);
        hold(1'b1, 2);
        checkv("R4 frame_err", frame_err, 1);
        checkv("R4 data delivered", rx_data, 8'h3C);
        pulse_clr();
        pulse_ack();

        // R10: clear during a frame leaves the frame intact
        v0 = vcnt;
        fork
            send_std(8'h96, 1'b0, 1'b0);
            begin
                repeat (4 * BIT) @(negedge clk);
                err_clr = 1'b1;
                @(negedge clk) err_clr = 1'b0;
            end
        join
        hold(1'b1, 1);
        checkv("R10 frame undisturbed", rx_data, 8'h96);
        checkv("R10 one character", vcnt - v0, 1);
        pulse_ack();

        // R10: clear in the very cycle the framing flag sets, set wins
        pulse_soft();
        cal = 0;
        fork
            begin
                repeat (5) @(negedge clk);
                send_std(8'h0F, 1'b1, 1'b0);
            end
            begin
                while (!rx_valid && cal < 20 * BIT) begin
                    @(negedge clk);
                    cal++;
                end
            end
        join
        hold(1'b1, 2);
        pulse_soft();
        fork
            begin
                repeat (5) @(negedge clk);
                send_std(8'h0F, 1'b1, 1'b0);
            end
            begin
                repeat (cal - 1) @(negedge clk);
                err_clr = 1'b1;
                @(negedge clk) err_clr = 1'b0;
                checkv("R10 set wins strobe seen", rx_valid, 1);
            end
        join
        hold(1'b1, 1);
        checkv("R10 set wins over clear", frame_err, 1);
        pulse_soft();

        // R5: held-low line restarts frames with no edge
        v0 = vcnt;
        send_std(8'h00, 1'b1, 1'b1);
        hold(1'b0, 20);
        hold(1'b1, 3);
        checkv("R5 three frames", vcnt - v0, 3);
        checkv("R5 data zero", last_data, 0);
        checkv("R5 frame_err", frame_err, 1);
        checkv("R8 long low break", break_det, 1);
        pulse_soft();

        // R6: enable toggle returns to idle and waits for an edge
        v0 = vcnt;
        send_std(8'h00, 1'b1, 1'b1);
        @(negedge clk) rx_en = 1'b0;
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        hold(1'b0, 5);
        checkv("R6 no restart", vcnt - v0, 1);
        checkv("R6 break count cleared", break_det, 0);
        hold(1'b1, 1);
        pulse_ack();
        send_std(8'h5A, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R6 edge restarts", vcnt - v0, 2);
        checkv("R6 data", rx_data, 8'h5A);
        pulse_soft();

        // R8: 10 bit times low gives no break, 11 bit times does
        hold(1'b0, 10);
        hold(1'b1, 2);
        checkv("R8 ten bits no break", break_det, 0);
        pulse_soft();
        rx_in = 1'b0;
        repeat (11 * BIT + 2 * (DIV + 1)) @(negedge clk);
        hold(1'b1, 2);
        checkv("R8 eleven bits break", break_det, 1);
        pulse_clr();
        checkv("R8 break cleared", break_det, 0);
        pulse_soft();

        // R9: second character before acknowledge
        send_std(8'h11, 1'b0, 1'b0);
        hold(1'b1, 1);
        send_std(8'h22, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R9 overrun", overrun_err, 1);
        checkv("R9 new data", rx_data, 8'h22);
        pulse_ack();

        // R11: new format ignored until soft reset, then applied
        pulse_soft();
        cfg_len_full = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_std(8'hC3, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R11 old format data", rx_data, 8'hC3);
        checkv("R11 old format no parity err", parity_err, 0);
        pulse_ack();
        pulse_soft();
        send(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hold(1'b1, 1);
        checkv("R11 new format data", rx_data, 8'h43);
        checkv("R11 new format parity ok", parity_err, 0);
        send(8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        hold(1'b1, 1);
        pulse_soft();
        checkv("R11 soft reset data", rx_data, 0);
        checkv("R11 soft reset frame_err", frame_err, 0);
        checkv("R11 soft reset overrun", overrun_err, 0);

        summary();
        $finish;
    end

endmodule